// File: doc/BRIEF.md
# Clock Output Enable Controller

This block decides, for every differential source clock output and every single-ended output, whether that output toggles or sits parked low. It combines external control pins with mirrored register bits, then applies a global source enable, a request input for each source output, a power-good input and a free-running setting for each source output. The output clocks are produced from a fast reference clock at half its rate. An output starts or stops only at a boundary where it is already low, so every phase it emits has full length.

The external pins are asynchronous and pass through a two-flop synchronizer. The register bits come from the same clock domain and are used directly. A status bit for each output shows whether that output is currently toggling.

Top module: `clk_out_gate`

## Requirements
- R1: The effective global source enable is high when `gen_pin` is high or `gen_bit` is high, and low only when both are low.
- R2: With power good and the effective global enable low, every source output whose `free_run` bit is 0 stops, whatever its request inputs are.
- R3: A source output whose `free_run` bit is 1 keeps running while the effective global enable is low, provided it is requested and power is good.
- R4: Source request inputs are active low. Output i is requested when `req_pin_n[i]` or `req_bit_n[i]` is 0, and released only when both are 1. A released output stops regardless of the enable and `free_run`.
- R5: While `pwrgd` is 0, every source output is stopped, regardless of all other inputs.
- R6: Single-ended output j runs when `oe_pin[j]` or `oe_bit[j]` is 1, and is stopped when both are 0.
- R7: A running output toggles at half the reference rate. Each high phase lasts exactly one reference cycle and begins only after an odd-numbered rising reference edge, counting the first edge after reset release as edge 1.
- R8: A stopped output is held low. An output is never high while its status bit is 0, and a status bit changes only at a point where its output is low.
- R9: In reset, and at the first sample after reset release, all outputs and all status bits are 0.
- R10: After the inputs change, a status bit settles to its new value within four reference cycles: two for the synchronizer and up to two more to reach a low boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwrgd | input | 1 | Power-good pin; 0 means power down (asynchronous) |
| gen_pin | input | 1 | Global source enable pin, active high (asynchronous) |
| gen_bit | input | 1 | Global source enable register bit, active high |
| req_pin_n | input | N_SRC | Request pin for each source output, active low (asynchronous) |
| req_bit_n | input | N_SRC | Request register bit for each source output, active low |
| free_run | input | N_SRC | 1 makes a source output ignore the global disable |
| oe_pin | input | N_SE | Output enable pin for each single-ended output (asynchronous) |
| oe_bit | input | N_SE | Output enable register bit for each single-ended output |
| src_clk | output | N_SRC | Gated source clocks |
| se_clk | output | N_SE | Gated single-ended clocks |
| src_run | output | N_SRC | Status: the source output is toggling |
| se_run | output | N_SE | Status: the single-ended output is toggling |

## Verification
Two functions can land on the same reference edge: a change to an output's enable, and the end of that output's high phase. The bench delays each new input setting by zero or one extra cycle, so changes reach the design at both phase parities across the truth-table walk. A phase monitor runs the whole time. It flags any high sample on an even-numbered edge, any high that lasts two samples, and any high while the status bit is low. Flagging these shows whether a stop or start has clipped a pulse.

// File: rtl/clk_out_gate.sv
module clk_out_gate #(
  parameter int N_SRC = 4,
  parameter int N_SE  = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             pwrgd,
  input  logic             gen_pin,
  input  logic             gen_bit,
  input  logic [N_SRC-1:0] req_pin_n,
  input  logic [N_SRC-1:0] req_bit_n,
  input  logic [N_SRC-1:0] free_run,
  input  logic [N_SE-1:0]  oe_pin,
  input  logic [N_SE-1:0]  oe_bit,
  output logic [N_SRC-1:0] src_clk,
  output logic [N_SE-1:0]  se_clk,
  output logic [N_SRC-1:0] src_run,
  output logic [N_SE-1:0]  se_run
);
  localparam int NPIN = 2 + N_SRC + N_SE;
  localparam logic [NPIN-1:0] PIN_RST = {{N_SE{1'b0}}, {N_SRC{1'b1}}, 2'b00};

  logic [NPIN-1:0]  pin_raw, sync_a, sync_b;
  logic             pwr_s, gen_s, phase;
  logic [N_SRC-1:0] req_s, src_want;
  logic [N_SE-1:0]  oe_s, se_want;

  assign pin_raw = {oe_pin, req_pin_n, gen_pin, pwrgd};

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      sync_a <= PIN_RST;
      sync_b <= PIN_RST;
    end else begin
      sync_a <= pin_raw;
      sync_b <= sync_a;
    end

  assign pwr_s = sync_b[0];
  assign gen_s = sync_b[1];
  assign req_s = sync_b[2 +: N_SRC];
  assign oe_s  = sync_b[2 + N_SRC +: N_SE];

  assign src_want = {N_SRC{pwr_s}} & ~(req_s & req_bit_n)
                  & ({N_SRC{gen_s | gen_bit}} | free_run);
  assign se_want  = oe_s | oe_bit;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      phase   <= 1'b0;
      src_run <= '0;
      se_run  <= '0;
      src_clk <= '0;
      se_clk  <= '0;
    end else begin
      phase   <= ~phase;
      src_clk <= src_run & {N_SRC{~phase}};
      se_clk  <= se_run & {N_SE{~phase}};
      if (phase) begin
        src_run <= src_want;
        se_run  <= se_want;
      end
    end
endmodule

// File: rtl/clk_out_gate_chk.sv
module clk_out_gate_chk #(
  parameter int N_SRC = 4,
  parameter int N_SE  = 2
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             pwrgd,
  input logic [N_SE-1:0]  oe_pin,
  input logic [N_SE-1:0]  oe_bit,
  input logic [N_SRC-1:0] src_clk,
  input logic [N_SE-1:0]  se_clk,
  input logic [N_SRC-1:0] src_run,
  input logic [N_SE-1:0]  se_run
);
  AST_SRC_HIGH_ONE_CYCLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (src_clk != '0) |=> ((src_clk & $past(src_clk)) == '0)); // R7
  AST_SE_HIGH_ONE_CYCLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (se_clk != '0) |=> ((se_clk & $past(se_clk)) == '0)); // R7
  AST_SRC_PARKED_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (src_clk & ~src_run) == '0); // R8
  AST_SE_PARKED_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (se_clk & ~se_run) == '0); // R8
  AST_POWER_DOWN_STOPS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!pwrgd && !$past(pwrgd) && !$past(pwrgd, 2) && !$past(pwrgd, 3) && !$past(pwrgd, 4))
      |-> (src_run == '0)); // R5

  for (genvar j = 0; j < N_SE; j++) begin : g_oe
    AST_OE_OFF_STOPS: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!(oe_pin[j] | oe_bit[j]) && !$past(oe_pin[j] | oe_bit[j])
       && !$past(oe_pin[j] | oe_bit[j], 2) && !$past(oe_pin[j] | oe_bit[j], 3)
       && !$past(oe_pin[j] | oe_bit[j], 4)) |-> !se_run[j]); // R6
  end
endmodule

bind clk_out_gate clk_out_gate_chk #(.N_SRC(N_SRC), .N_SE(N_SE)) chk_i (.*);

// File: tb/clk_out_gate_tb_top.sv
module clk_out_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NE = 2;

  typedef struct packed {
    logic [NS-1:0] src;
    logic [NE-1:0] se;
  } exp_t;

  logic          clk_ref = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwrgd = 1'b0, gen_pin = 1'b0, gen_bit = 1'b0;
  logic [NS-1:0] req_pin_n = '1, req_bit_n = '1, free_run = '0;
  logic [NE-1:0] oe_pin = '0, oe_bit = '0;
  logic [NS-1:0] src_clk, src_run;
  logic [NE-1:0] se_clk, se_run;

  int   n_chk = 0, n_bad = 0, edge_no = 0, phase_bad = 0;
  bit   mon_busy = 1'b0;
  bit   done = 1'b0;
  exp_t exp_q[$];
  logic [NS-1:0] prev_src = '0;
  logic [NE-1:0] prev_se = '0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  clk_out_gate #(.N_SRC(NS), .N_SE(NE)) dut_i (.*);

  always @(posedge clk_ref) if (rst_n) edge_no <= edge_no + 1;

  // Phase monitor: R7 and R8, active for the whole run
  always @(negedge clk_ref) if (rst_n) begin
    for (int i = 0; i < NS; i++) begin
      if (src_clk[i] && (edge_no % 2 == 0)) begin
        phase_bad++; $display("FAIL R7 src%0d high after edge %0d: act=1 exp=0", i, edge_no);
      end
      if (src_clk[i] && prev_src[i]) begin
        phase_bad++; $display("FAIL R7 src%0d high two samples: act=1 exp=0", i);
      end
      if (src_clk[i] && !src_run[i]) begin
        phase_bad++; $display("FAIL R8 src%0d high while stopped: act=1 exp=0", i);
      end
    end
    for (int j = 0; j < NE; j++) begin
      if (se_clk[j] && ((edge_no % 2 == 0) || prev_se[j] || !se_run[j])) begin
        phase_bad++; $display("FAIL R7 R8 se%0d bad high phase: act=1 exp=0", j);
      end
    end
    prev_src = src_clk;
    prev_se  = se_clk;
  end

  function automatic exp_t model();
    exp_t e;
    e.src = {NS{pwrgd}} & ~(req_pin_n & req_bit_n) & ({NS{gen_pin | gen_bit}} | free_run);
    e.se  = oe_pin | oe_bit;
    return e;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares status and toggling
  initial forever begin
    exp_t e;
    int hs [NS];
    int he [NE];
    wait (exp_q.size() > 0);
    mon_busy = 1'b1;
    e = exp_q.pop_front();
    @(negedge clk_ref);
    check("R1 R2 R3 R4 R5 R10 src_run", int'(src_run), int'(e.src));
    check("R6 R10 se_run", int'(se_run), int'(e.se));
    for (int i = 0; i < NS; i++) hs[i] = 0;
    for (int j = 0; j < NE; j++) he[j] = 0;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < NS; i++) hs[i] += int'(src_clk[i]);
      for (int j = 0; j < NE; j++) he[j] += int'(se_clk[j]);
      @(negedge clk_ref);
    end
    for (int i = 0; i < NS; i++) check("R7 R8 src high count", hs[i], e.src[i] ? 2 : 0);
    for (int j = 0; j < NE; j++) check("R7 R8 se high count", he[j], e.se[j] ? 2 : 0);
    mon_busy = 1'b0;
  end

  // Driver: applies a setting at either phase parity, then pushes the expectation
  task automatic apply(input logic pg, input logic gp, input logic gb,
                       input logic [NS-1:0] rp, input logic [NS-1:0] rb,
                       input logic [NS-1:0] fr, input logic [NE-1:0] op,
                       input logic [NE-1:0] ob, input bit skew);
    if (skew) @(posedge clk_ref);
    @(negedge clk_ref);
    pwrgd = pg; gen_pin = gp; gen_bit = gb;
    req_pin_n = rp; req_bit_n = rb; free_run = fr;
    oe_pin = op; oe_bit = ob;
    repeat (8) @(posedge clk_ref);
    exp_q.push_back(model());
    wait (exp_q.size() == 0 && !mon_busy);
  endtask

  initial begin
    logic [NS-1:0] fr_set [3];
    fr_set[0] = 4'b0000; fr_set[1] = 4'b1111; fr_set[2] = 4'b1010;
    repeat (3) @(negedge clk_ref);
    check("R9 reset src_run", int'(src_run), 0);
    check("R9 reset src_clk", int'(src_clk), 0);
    rst_n = 1'b1;
    @(negedge clk_ref);
    check("R9 first sample src_run", int'(src_run), 0);
    check("R9 first sample se_run", int'(se_run), 0);
    for (int f = 0; f < 3; f++)
      for (int k = 0; k < 8; k++) begin
        logic [2:0] kb;
        kb = 3'(k);
        apply(kb[2], kb[1], kb[0], 4'b0101, 4'b0011, fr_set[f],
              {kb[1], kb[0]}, {kb[2], kb[1]}, bit'((k + f) % 2));
      end
    // R4: release by making both request sources high, then re-request by one
    apply(1'b1, 1'b1, 1'b0, 4'b1111, 4'b1111, 4'b0000, 2'b11, 2'b00, 1'b0);
    apply(1'b1, 1'b1, 1'b0, 4'b1111, 4'b1110, 4'b0000, 2'b00, 2'b01, 1'b1);
    // R5: power down with everything else asking to run
    apply(1'b0, 1'b1, 1'b1, 4'b0000, 4'b0000, 4'b1111, 2'b11, 2'b11, 1'b0);
    n_chk++;
    if (phase_bad != 0) n_bad++;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_ref);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule